// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block places a calendar clock in the top eight byte addresses of a byte-wide memory space. It keeps seconds, minutes, hours, day of week, date, month, year and century as packed BCD values and moves them forward once per second. The second is derived from a free-running oscillator tick input divided by a parameter. Every address below the clock window is passed unchanged to an external RAM port, so the block fits in front of an ordinary static RAM.

The bus side is a synchronous form of a static-RAM interface: active-low chip enable, output enable and write enable, an address and a byte of write data. Reads are combinational from the selected byte. A write takes effect on each clock edge where chip enable and write enable are both low.

Software uses a few control bits in the clock registers. One bit stops the oscillator. One enables a square-wave test output. One bit freezes the visible registers so they read consistently. Another suspends visible counting while new time values are written, and commits those values when it is cleared. Bits with no clock function behave as plain storage. The battery flag is a read-only copy of an input.

Top module: `rtc_bcd_regfile`

## Requirements
- R1: The clock occupies byte addresses 2^ADDR_W-8 to 2^ADDR_W-1. The register index is the low three address bits: 0 century/control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. After reset the time reads century 00, 00:00:00, day 01, date 01, month 01, year 00, and all control and spare bits are 0.
- R2: A read is ce_n=0, oe_n=0, we_n=1, and rdata shows the selected byte. A write is ce_n=0, we_n=0. rdata is 0 whenever no read is in progress.
- R3: Seconds and minutes count 00-59 and hours count 00-23 in BCD. Each carries into the next on wrap. Day of week counts 01-07 and advances, with date, when the hours wrap.
- R4: Date wraps to 01 after the last day of the month. The month lengths are 30 days for 04/06/09/11, 31 days for the other months except February, and 29 days for February when the binary value of the BCD year is divisible by 4, else 28.
- R5: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century, which wraps from 39 to 00.
- R6: Bit 7 of index 0 is the write-hold bit. While it is 1, the visible time fields stop following the counters and take written values. The write that changes it from 1 to 0 copies the visible time fields into the counters and restarts the sub-second divider.
- R7: A write to a time field while the write-hold bit is 0 does not change the time.
- R8: Bit 6 of index 0 is the read-freeze bit. While it is 1, the visible time fields hold a snapshot and the counters keep running. When it returns to 0, reads show the live time again.
- R9: Bit 7 of index 1 stops the oscillator. While it is 1, no second advances and the divider holds.
- R10: Non-clock bits read back as written. These are bit 7 of minutes, bits 7:6 of hours, bits 5:3 of day, bits 7:6 of date and bits 7:5 of month.
- R11: Bit 7 of index 4 reads the batt_ok input. Writes to that bit have no effect on the value read.
- R12: Bit 6 of index 4 enables the test output. While it is 1 and the oscillator runs, ft_out toggles every max(1, PRESCALE/1024) osc_tick pulses, which is 512 Hz when the tick rate is PRESCALE Hz. Otherwise ft_out is 0.
- R13: For addresses below the clock window, ext_ce_n follows ce_n and rdata shows ext_rdata during a read. ext_oe_n, ext_we_n, ext_addr and ext_wdata always equal their bus inputs. ext_ce_n is 1 for addresses inside the window.
- R14: One second elapses every PRESCALE osc_tick pulses, counted from reset or from the last commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle oscillator pulse, PRESCALE per second |
| batt_ok | input | 1 | Battery status shown in the day register |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| ft_out | output | 1 | Frequency test square wave |
| ext_ce_n | output | 1 | Chip enable to external RAM |
| ext_oe_n | output | 1 | Output enable to external RAM |
| ext_we_n | output | 1 | Write enable to external RAM |
| ext_addr | output | ADDR_W | Address to external RAM |
| ext_wdata | output | 8 | Write data to external RAM |
| ext_rdata | input | 8 | Read data from external RAM |

## Verification
The bench builds the block with ADDR_W=17 and PRESCALE=4. At that setting a second lasts four ticks and the test output toggles on every tick. This puts all 100 years of February rollover, every month end in four different years, and the century wrap within a few thousand cycles. Expected times come from plain integer calendar arithmetic in the bench, converted to BCD only for comparison.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  typedef logic [7:0] byte_t;
  typedef logic [7:0][7:0] bank_t;

  localparam int IDX_CEN  = 0;
  localparam int IDX_SEC  = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_HR   = 3;
  localparam int IDX_DAY  = 4;
  localparam int IDX_DATE = 5;
  localparam int IDX_MON  = 6;
  localparam int IDX_YR   = 7;

  // index 7 down to 0: year, month, date, day, hour, minute, second, century
  localparam bank_t RESET_BANK = {8'h00, 8'h01, 8'h01, 8'h01,
                                  8'h00, 8'h00, 8'h00, 8'h00};

  // bits that belong to the time value in each register
  function automatic byte_t tmask(input logic [2:0] i);
    case (i)
      3'd0: return 8'h3F;
      3'd1: return 8'h7F;
      3'd2: return 8'h7F;
      3'd3: return 8'h3F;
      3'd4: return 8'h07;
      3'd5: return 8'h3F;
      3'd6: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcd2bin(input byte_t b);
    return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
  endfunction

  function automatic byte_t bin2bcd(input logic [7:0] v);
    return {4'(v / 8'd10), 4'(v % 8'd10)};
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                    return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bus_decode.sv
`timescale 1ns/1ps
module rtc_bus_decode #(
  parameter int ADDR_W = 17
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              rd_any,
  output logic              wr_clk,
  output logic [2:0]        idx,
  output logic              ext_ce_n
);
  localparam int HI_W = ADDR_W - 3;

  assign hit      = (addr[ADDR_W-1:3] == {HI_W{1'b1}});
  assign idx      = addr[2:0];
  assign rd_any   = !ce_n && !oe_n && we_n;
  assign wr_clk   = !ce_n && !we_n && hit;
  assign ext_ce_n = ce_n || hit;
endmodule

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int PRESCALE = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic run,
  input  logic clr,
  input  logic ft_en,
  output logic sec_pulse,
  output logic ft_out
);
  localparam int PW      = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int FT_HALF = (PRESCALE / 1024 > 0) ? PRESCALE / 1024 : 1;
  localparam int FW      = (FT_HALF > 1) ? $clog2(FT_HALF) : 1;
  localparam logic [PW-1:0] PC_LAST = PW'(PRESCALE - 1);
  localparam logic [FW-1:0] FT_LAST = FW'(FT_HALF - 1);

  logic [PW-1:0] pc_q;
  logic [FW-1:0] fc_q;
  logic          ft_active;

  assign sec_pulse = osc_tick && run && !clr && (pc_q == PC_LAST);
  assign ft_active = ft_en && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (clr) begin
      pc_q <= '0;
    end else if (osc_tick && run) begin
      pc_q <= (pc_q == PC_LAST) ? '0 : pc_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q   <= '0;
      ft_out <= 1'b0;
    end else if (!ft_active) begin
      fc_q   <= '0;
      ft_out <= 1'b0;
    end else if (osc_tick) begin
      if (fc_q == FT_LAST) begin
        fc_q   <= '0;
        ft_out <= !ft_out;
      end else begin
        fc_q <= fc_q + FW'(1);
      end
    end
  end

  // R14
  sec_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> (osc_tick && run));
  // R12
  ft_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ft_active |=> !ft_out);
  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pc_q));
endmodule

// File: rtl/rtc_cal_advance.sv
`timescale 1ns/1ps
module rtc_cal_advance
  import rtc_cal_pkg::*;
(
  input  bank_t cur,
  input  logic  step,
  output bank_t nxt
);
  logic [7:0] v_sec, v_min, v_hr, v_day, v_date, v_mon, v_yr, v_cen, dim;
  logic       carry;

  always_comb begin
    v_sec  = bcd2bin(cur[IDX_SEC]  & tmask(3'(IDX_SEC)));
    v_min  = bcd2bin(cur[IDX_MIN]  & tmask(3'(IDX_MIN)));
    v_hr   = bcd2bin(cur[IDX_HR]   & tmask(3'(IDX_HR)));
    v_day  = bcd2bin(cur[IDX_DAY]  & tmask(3'(IDX_DAY)));
    v_date = bcd2bin(cur[IDX_DATE] & tmask(3'(IDX_DATE)));
    v_mon  = bcd2bin(cur[IDX_MON]  & tmask(3'(IDX_MON)));
    v_yr   = bcd2bin(cur[IDX_YR]);
    v_cen  = bcd2bin(cur[IDX_CEN]  & tmask(3'(IDX_CEN)));
    dim    = month_days(v_mon, v_yr);
    carry  = step;

    if (carry) begin
      if (v_sec >= 8'd59) v_sec = 8'd0;
      else begin v_sec = v_sec + 8'd1; carry = 1'b0; end
    end
    if (carry) begin
      if (v_min >= 8'd59) v_min = 8'd0;
      else begin v_min = v_min + 8'd1; carry = 1'b0; end
    end
    if (carry) begin
      if (v_hr >= 8'd23) v_hr = 8'd0;
      else begin v_hr = v_hr + 8'd1; carry = 1'b0; end
    end
    if (carry) begin
      v_day = (v_day >= 8'd7) ? 8'd1 : v_day + 8'd1;
      if (v_date >= dim) v_date = 8'd1;
      else begin v_date = v_date + 8'd1; carry = 1'b0; end
    end
    if (carry) begin
      if (v_mon >= 8'd12) v_mon = 8'd1;
      else begin v_mon = v_mon + 8'd1; carry = 1'b0; end
    end
    if (carry) begin
      if (v_yr >= 8'd99) v_yr = 8'd0;
      else begin v_yr = v_yr + 8'd1; carry = 1'b0; end
    end
    if (carry) begin
      v_cen = (v_cen >= 8'd39) ? 8'd0 : v_cen + 8'd1;
    end

    nxt = cur;
    nxt[IDX_SEC]  = (cur[IDX_SEC]  & ~tmask(3'(IDX_SEC)))  | bin2bcd(v_sec);
    nxt[IDX_MIN]  = (cur[IDX_MIN]  & ~tmask(3'(IDX_MIN)))  | bin2bcd(v_min);
    nxt[IDX_HR]   = (cur[IDX_HR]   & ~tmask(3'(IDX_HR)))   | bin2bcd(v_hr);
    nxt[IDX_DAY]  = (cur[IDX_DAY]  & ~tmask(3'(IDX_DAY)))  | bin2bcd(v_day);
    nxt[IDX_DATE] = (cur[IDX_DATE] & ~tmask(3'(IDX_DATE))) | bin2bcd(v_date);
    nxt[IDX_MON]  = (cur[IDX_MON]  & ~tmask(3'(IDX_MON)))  | bin2bcd(v_mon);
    nxt[IDX_YR]   = bin2bcd(v_yr);
    nxt[IDX_CEN]  = (cur[IDX_CEN]  & ~tmask(3'(IDX_CEN)))  | bin2bcd(v_cen);
  end
endmodule

// File: rtl/rtc_bcd_regfile.sv
`timescale 1ns/1ps
module rtc_bcd_regfile
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int PRESCALE = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              batt_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              ft_out,
  output logic              ext_ce_n,
  output logic              ext_oe_n,
  output logic              ext_we_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [7:0]        ext_wdata,
  input  logic [7:0]        ext_rdata
);
  logic       hit, rd_any, wr_clk;
  logic [2:0] idx;
  bank_t      cnt_q, cnt_adv, vis_q, vis_nxt, aux_q, view;
  byte_t      rbyte;
  logic       w_bit, r_bit, osc_stop, ft_en, freeze, load_evt, sec_pulse;

  rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .hit(hit), .rd_any(rd_any), .wr_clk(wr_clk), .idx(idx), .ext_ce_n(ext_ce_n)
  );

  assign ext_oe_n  = oe_n;
  assign ext_we_n  = we_n;
  assign ext_addr  = addr;
  assign ext_wdata = wdata;

  assign w_bit    = aux_q[IDX_CEN][7];
  assign r_bit    = aux_q[IDX_CEN][6];
  assign osc_stop = aux_q[IDX_SEC][7];
  assign ft_en    = aux_q[IDX_DAY][6];
  assign freeze   = w_bit || r_bit;
  assign load_evt = wr_clk && (idx == 3'(IDX_CEN)) && w_bit && !wdata[7];

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .run(!osc_stop),
    .clr(load_evt), .ft_en(ft_en), .sec_pulse(sec_pulse), .ft_out(ft_out)
  );

  rtc_cal_advance u_adv (.cur(cnt_q), .step(sec_pulse), .nxt(cnt_adv));

  // visible time bank: tracks the counters unless frozen, takes time-bit writes
  always_comb begin
    vis_nxt = freeze ? vis_q : cnt_adv;
    if (wr_clk) vis_nxt[idx] = (vis_nxt[idx] & ~tmask(idx)) | (wdata & tmask(idx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RESET_BANK;
      vis_q <= RESET_BANK;
    end else begin
      cnt_q <= load_evt ? vis_nxt : cnt_adv;
      vis_q <= vis_nxt;
    end
  end

  // control and spare storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aux_q <= '0;
    else if (wr_clk) aux_q[idx] <= wdata;
  end

  always_comb begin
    view  = freeze ? vis_q : cnt_q;
    rbyte = (aux_q[idx] & ~tmask(idx)) | (view[idx] & tmask(idx));
    if (idx == 3'(IDX_DAY)) rbyte[7] = batt_ok;
    if (!rd_any)  rdata = '0;
    else if (hit) rdata = rbyte;
    else          rdata = ext_rdata;
  end

  // R9
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && !load_evt) |=> $stable(cnt_q));
  // R9
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> !osc_stop);
  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_clk) |=> $stable(vis_q));
  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !load_evt && cnt_q[IDX_SEC] == 8'h59) |=> (cnt_q[IDX_SEC] == 8'h00));
  // R6
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cnt_q == $past(vis_nxt)));
  // R13
  ext_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ext_ce_n);
endmodule

// File: tb/sim_rtc_bcd_regfile.sv
`timescale 1ns/1ps
module sim_rtc_bcd_regfile;
  localparam int AW = 17;
  localparam int PS = 4;
  localparam logic [7:0] TM [8] = '{8'h3F, 8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, osc_tick = 1'b0, batt_ok = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, ext_rdata = 8'hA5;
  logic [7:0] rdata, ext_wdata;
  logic ft_out, ext_ce_n, ext_oe_n, ext_we_n;
  logic [AW-1:0] ext_addr;

  rtc_bcd_regfile #(.ADDR_W(AW), .PRESCALE(PS)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .batt_ok(batt_ok),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ft_out(ft_out), .ext_ce_n(ext_ce_n), .ext_oe_n(ext_oe_n),
    .ext_we_n(ext_we_n), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [AW-1:0] ra(input int i);
    return 17'h1FFF8 + 17'(i);
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = a; wdata = d;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    #1 d = rdata;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); osc_tick = 1;
      @(negedge clk); osc_tick = 0;
    end
  endtask

  task automatic set_time(input int cen, yr, mo, dt, dy, hr, mi, se);
    wr(ra(0), 8'h80 | bcd(cen));
    wr(ra(1), bcd(se)); wr(ra(2), bcd(mi)); wr(ra(3), bcd(hr));
    wr(ra(4), bcd(dy)); wr(ra(5), bcd(dt)); wr(ra(6), bcd(mo));
    wr(ra(7), bcd(yr));
    wr(ra(0), bcd(cen));
  endtask

  task automatic chk_time(input string req, input int cen, yr, mo, dt, dy, hr, mi, se);
    logic [7:0] d;
    int exp_v [8];
    exp_v = '{cen, se, mi, hr, dy, dt, mo, yr};
    for (int i = 0; i < 8; i++) begin
      rd(ra(i), d);
      chk(req, d & TM[i], bcd(exp_v[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state and address order
    chk_time("R1 reset", 0, 0, 1, 1, 1, 0, 0, 0);
    rd(ra(0), d); chk("R1 control clear", d, 8'h00);
    rd(ra(4), d); chk("R1 day+batt", d, 8'h81);

    // R14 divider: PS-1 ticks no change, PS ticks one second
    tick(PS - 1); rd(ra(1), d); chk("R14 partial second", d, 8'h00);
    tick(1);      rd(ra(1), d); chk("R14 full second", d, 8'h01);

    // R4 R5 R3 month-end sweep across several years, century 39
    foreach (TM[j]) begin end
    for (int yi = 0; yi < 4; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        int y, dm, dy, ndt, nmo, nyr, ncen;
        y  = (yi == 0) ? 0 : (yi == 1) ? 23 : (yi == 2) ? 24 : 99;
        dm = mdays(m, y);
        dy = (m % 7) + 1;
        set_time(39, y, m, dm, dy, 23, 59, 59);
        tick(PS);
        ndt = 1; nmo = (m == 12) ? 1 : m + 1;
        nyr = (m == 12) ? ((y == 99) ? 0 : y + 1) : y;
        ncen = (m == 12 && y == 99) ? 0 : 39;
        chk_time("R4 R5 R3 month end", ncen, nyr, nmo, ndt, (dy == 7) ? 1 : dy + 1, 0, 0, 0);
      end
    end

    // R4 February 28 across all 100 years
    for (int y = 0; y < 100; y++) begin
      set_time(20, y, 2, 28, 1, 23, 59, 59);
      tick(PS);
      rd(ra(5), d); chk("R4 feb date", d & 8'h3F, (y % 4 == 0) ? 8'h29 : 8'h01);
      rd(ra(6), d); chk("R4 feb month", d & 8'h1F, (y % 4 == 0) ? 8'h02 : 8'h03);
    end

    // R3 continuous counting through minute and hour carry
    set_time(20, 24, 6, 15, 3, 12, 58, 0);
    for (int k = 1; k <= 120; k++) begin
      int t;
      tick(PS);
      t = 12 * 3600 + 58 * 60 + k;
      rd(ra(1), d); chk("R3 seconds", d, bcd(t % 60));
      rd(ra(2), d); chk("R3 minutes", d, bcd((t / 60) % 60));
      rd(ra(3), d); chk("R3 hours", d, bcd(t / 3600));
    end

    // R6 write-hold: freeze, take written value, commit on clear
    wr(ra(0), 8'hA0);
    tick(PS);
    rd(ra(1), d); chk("R6 visible frozen", d, 8'h00);
    wr(ra(1), 8'h10);
    rd(ra(1), d); chk("R6 written visible", d, 8'h10);
    wr(ra(0), 8'h20);
    rd(ra(1), d); chk("R6 committed", d, 8'h10);
    tick(PS);
    rd(ra(1), d); chk("R6 counts from commit", d, 8'h11);

    // R7 time write without hold has no effect
    wr(ra(1), 8'h45);
    rd(ra(1), d); chk("R7 write ignored", d, 8'h11);
    tick(PS);
    rd(ra(1), d); chk("R7 still counting", d, 8'h12);

    // R8 read freeze
    wr(ra(0), 8'h60);
    tick(2 * PS);
    rd(ra(1), d); chk("R8 snapshot", d, 8'h12);
    wr(ra(0), 8'h20);
    rd(ra(1), d); chk("R8 live after release", d, 8'h14);

    // R9 oscillator stop
    wr(ra(1), 8'h80);
    tick(2 * PS);
    rd(ra(1), d); chk("R9 halted", d, 8'h94);
    wr(ra(1), 8'h00);
    tick(PS);
    rd(ra(1), d); chk("R9 resumed", d, 8'h15);

    // R10 spare bits
    wr(ra(2), 8'h80); rd(ra(2), d); chk("R10 minutes spare", d, 8'h80);
    wr(ra(3), 8'hC0); rd(ra(3), d); chk("R10 hours spare", d, 8'hD3);
    wr(ra(5), 8'hC0); rd(ra(5), d); chk("R10 date spare", d, 8'hD5);
    wr(ra(6), 8'hE0); rd(ra(6), d); chk("R10 month spare", d, 8'hE6);
    wr(ra(4), 8'h38); rd(ra(4), d); chk("R10 day spare", d, 8'hBB);

    // R11 battery flag
    batt_ok = 0;
    rd(ra(4), d); chk("R11 batt low", d, 8'h3B);
    wr(ra(4), 8'hB8);
    rd(ra(4), d); chk("R11 write ignored", d, 8'h3B);
    batt_ok = 1;
    rd(ra(4), d); chk("R11 batt high", d, 8'hBB);

    // R12 frequency test output
    wr(ra(4), 8'h40);
    chk("R12 ft start", ft_out, 0);
    tick(1); chk("R12 ft toggle1", ft_out, 1);
    tick(1); chk("R12 ft toggle2", ft_out, 0);
    tick(1); chk("R12 ft toggle3", ft_out, 1);
    wr(ra(1), 8'h80);
    @(negedge clk); chk("R12 ft off when stopped", ft_out, 0);
    wr(ra(1), 8'h00);
    wr(ra(4), 8'h00);
    tick(1); chk("R12 ft off when disabled", ft_out, 0);

    // R2 no read strobe gives zero
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; addr = ra(3);
    #1 chk("R2 idle rdata", rdata, 8'h00);
    ce_n = 1;

    // R13 external pass-through
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = 17'h00123;
    #1;
    chk("R13 ext ce", ext_ce_n, 0);
    chk("R13 ext addr", ext_addr, 17'h00123);
    chk("R13 ext rdata", rdata, 8'hA5);
    addr = ra(2);
    #0.5 chk("R13 ext blocked", ext_ce_n, 1);
    addr = 17'h00456; oe_n = 1; we_n = 0; wdata = 8'h3C;
    #0.5;
    chk("R13 ext we", ext_we_n, 0);
    chk("R13 ext wdata", ext_wdata, 8'h3C);
    chk("R13 ext oe", ext_oe_n, 1);
    ce_n = 1; we_n = 1;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule